// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Threshold Interrupts

This block sits between a word-wide register port and a serial shift engine. It holds two
first-in first-out buffers of sixteen words each. Software fills the transmit buffer by
writing a data register, and the shift engine drains it through a pop port. The shift engine
fills the receive buffer through a push port, and software drains it by reading a data
register. The fill level of each buffer is readable from a shared status word.

Each direction has a flag word, an enable word and a clear word. Full, empty and threshold
flags follow the live fill counts. A release flag is latched when the engine reports that
the peripheral select has been released, and it stays set until software clears it. Each
direction drives one registered interrupt line from its enabled flags. Writes to the
configuration word set both thresholds, and one-cycle flush commands in the same word empty
either buffer.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each buffer holds 16 words and returns them in the order they were written. Transmit words are written at address 8 and popped by the engine; receive words are pushed by the engine and read at address 9.
- R2: The status word at address 0 reports the receive level in bits 12:8 and the transmit level in bits 20:16. All other bits read 0.
- R3: A push into a full buffer and a pop from an empty buffer are ignored. The level stays unchanged, and no engine data-valid pulse follows an ignored pop.
- R4: The configuration word at address 1 stores the receive threshold in bits 3:0 and the transmit threshold in bits 7:4. Writing 1 to bit 11 empties the receive buffer and writing 1 to bit 12 empties the transmit buffer. Flush bits read back 0 and do not disturb the thresholds.
- R5: The transmit flag word at address 2 has bit 0 set when the level is 16, bit 1 set when the level is 0, and bit 5 set when the level is at or below the transmit threshold.
- R6: The receive flag word at address 5 has bit 5 set when the level is strictly above the receive threshold.
- R7: A one-cycle `slave_rel` pulse sets bit 6 in both flag words. The bit stays set until a 1 is written to bit 6 of that direction's clear word (address 4 for transmit, 7 for receive). Clear writes with bit 6 at 0 change nothing.
- R8: The enable words (address 3 for transmit, 6 for receive) store only the implemented flag bits: mask 0x63 for transmit and 0x60 for receive.
- R9: Each interrupt line is high exactly when its direction has a flag set together with the matching enable bit. The line follows one clock after that condition changes.
- R10: Reading the receive data address while the receive buffer is empty returns 0.
- R11: Read data appears on `reg_rdata` in the cycle after the `reg_re` strobe. An accepted engine pop presents its word with `eng_tx_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_re` |
| eng_tx_pop | input | 1 | Engine takes one transmit word |
| eng_tx_data | output | DW | Popped transmit word |
| eng_tx_valid | output | 1 | `eng_tx_data` holds a freshly popped word |
| eng_rx_push | input | 1 | Engine delivers one receive word |
| eng_rx_data | input | DW | Received word |
| slave_rel | input | 1 | Event pulse: peripheral select released |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
Transmit traffic is driven first as a full burst of sixteen writes followed by a full drain. It is then driven as interleaved pushes and pops, so that pointer wrap and the case of pops overtaking writes are separated from plain sequential order. Receive traffic is driven at levels just below, at and above the threshold, and then beyond capacity. This tells a strict comparison apart from an inclusive one, and shows whether overflow data is dropped or overwrites stored data. Flush commands are issued with words still stored, and clear words are written with bit 6 both set and unset. Together these show whether flushes discard data and whether the release latch honours only its own bit.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 4'd0,
    A_CFG    = 4'd1,
    A_TXFLG  = 4'd2,
    A_TXEN   = 4'd3,
    A_TXCLR  = 4'd4,
    A_RXFLG  = 4'd5,
    A_RXEN   = 4'd6,
    A_RXCLR  = 4'd7,
    A_TXDAT  = 4'd8,
    A_RXDAT  = 4'd9
  } reg_addr_e;

  // flag word bit positions (shared layout, both directions)
  localparam int B_FULL  = 0;
  localparam int B_EMPTY = 1;
  localparam int B_THR   = 5;
  localparam int B_REL   = 6;

  // configuration word fields
  localparam int THR_W      = 4;
  localparam int RXTHR_LSB  = 0;
  localparam int TXTHR_LSB  = 4;
  localparam int B_RXFLUSH  = 11;
  localparam int B_TXFLUSH  = 12;

  // status word fields
  localparam int LVL_FIELD_W = 5;
  localparam int RXLVL_LSB   = 8;
  localparam int TXLVL_LSB   = 16;

  localparam logic [7:0] TX_FLAG_MASK = 8'h63;
  localparam logic [7:0] RX_FLAG_MASK = 8'h60;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign push_ok = push && !flush && (count != CW'(DEPTH));
  assign pop_ok  = pop  && !flush && (count != '0);

  // storage and read port without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  pop_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pop_valid <= 1'b0;
    else     pop_valid <= pop_ok;
  end
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter logic [7:0] MASK = 8'h63
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] live,
  input  logic       rel_evt,
  input  logic       en_we,
  input  logic       clr_we,
  input  logic [7:0] wdata,
  output logic [7:0] flags,
  output logic [7:0] en,
  output logic       irq
);
  logic rel_q;

  always_ff @(posedge clk) begin
    if (rst)                         rel_q <= 1'b0;
    else if (rel_evt)                rel_q <= 1'b1;
    else if (clr_we && wdata[B_REL]) rel_q <= 1'b0;
  end

  always_comb begin
    flags        = live & MASK;
    flags[B_REL] = rel_q & MASK[B_REL];
  end

  always_ff @(posedge clk) begin
    if (rst)        en <= '0;
    else if (en_we) en <= wdata & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & en);
  end
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              eng_tx_pop,
  output logic [DW-1:0]     eng_tx_data,
  output logic              eng_tx_valid,
  input  logic              eng_rx_push,
  input  logic [DW-1:0]     eng_rx_data,
  input  logic              slave_rel,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [DW-1:0]    rx_dout;
  logic             rx_pop_valid;
  logic             tx_push, rx_pop, tx_flush, rx_flush;
  logic             cfg_we;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [7:0]       tx_live, rx_live, tx_flags, rx_flags, tx_en, rx_en;
  logic [REG_W-1:0] rdata_q;
  logic             fifo_sel_q;

  // register-side decode
  assign cfg_we   = reg_we && (reg_addr == A_CFG);
  assign tx_push  = reg_we && (reg_addr == A_TXDAT);
  assign rx_pop   = reg_re && (reg_addr == A_RXDAT);
  assign tx_flush = cfg_we && reg_wdata[B_TXFLUSH];
  assign rx_flush = cfg_we && reg_wdata[B_RXFLUSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (cfg_we) begin
      rx_thr <= reg_wdata[RXTHR_LSB +: THR_W];
      tx_thr <= reg_wdata[TXTHR_LSB +: THR_W];
    end
  end

  spi_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .push_data(reg_wdata[DW-1:0]),
    .pop(eng_tx_pop), .pop_data(eng_tx_data), .pop_valid(eng_tx_valid),
    .count(tx_cnt)
  );

  spi_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rx_pop), .pop_data(rx_dout), .pop_valid(rx_pop_valid),
    .count(rx_cnt)
  );

  // live flag sources from the counts
  always_comb begin
    tx_live          = '0;
    tx_live[B_FULL]  = (tx_cnt == CW'(DEPTH));
    tx_live[B_EMPTY] = (tx_cnt == '0);
    tx_live[B_THR]   = (int'(tx_cnt) <= int'(tx_thr));
    rx_live          = '0;
    rx_live[B_THR]   = (int'(rx_cnt) > int'(rx_thr));
  end

  spi_fifo_irq #(.MASK(TX_FLAG_MASK)) u_txirq (
    .clk(clk), .rst(rst), .live(tx_live), .rel_evt(slave_rel),
    .en_we(reg_we && (reg_addr == A_TXEN)),
    .clr_we(reg_we && (reg_addr == A_TXCLR)),
    .wdata(reg_wdata[7:0]), .flags(tx_flags), .en(tx_en), .irq(irq_tx)
  );

  spi_fifo_irq #(.MASK(RX_FLAG_MASK)) u_rxirq (
    .clk(clk), .rst(rst), .live(rx_live), .rel_evt(slave_rel),
    .en_we(reg_we && (reg_addr == A_RXEN)),
    .clr_we(reg_we && (reg_addr == A_RXCLR)),
    .wdata(reg_wdata[7:0]), .flags(rx_flags), .en(rx_en), .irq(irq_rx)
  );

  // registered read path; the receive word comes from the buffer read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      fifo_sel_q <= 1'b0;
    end else begin
      fifo_sel_q <= rx_pop && (rx_cnt != '0);
      if (reg_re) begin
        rdata_q <= '0;
        case (reg_addr)
          A_STATUS: begin
            rdata_q[RXLVL_LSB +: LVL_FIELD_W] <= LVL_FIELD_W'(rx_cnt);
            rdata_q[TXLVL_LSB +: LVL_FIELD_W] <= LVL_FIELD_W'(tx_cnt);
          end
          A_CFG: begin
            rdata_q[RXTHR_LSB +: THR_W] <= rx_thr;
            rdata_q[TXTHR_LSB +: THR_W] <= tx_thr;
          end
          A_TXFLG: rdata_q[7:0] <= tx_flags;
          A_TXEN:  rdata_q[7:0] <= tx_en;
          A_RXFLG: rdata_q[7:0] <= rx_flags;
          A_RXEN:  rdata_q[7:0] <= rx_en;
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = (fifo_sel_q && rx_pop_valid) ? REG_W'(rx_dout) : rdata_q;
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_push,
  input logic          eng_tx_pop,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          slave_rel,
  input logic [7:0]    tx_flags,
  input logic [7:0]    rx_flags,
  input logic [7:0]    tx_en,
  input logic [7:0]    rx_en,
  input logic          irq_tx,
  input logic          irq_rx
);
  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == CW'(DEPTH) && tx_push && !eng_tx_pop && !tx_flush) |=> (tx_cnt == CW'(DEPTH)));

  p_rx_flush_r4: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (rx_cnt == '0));

  p_tx_flush_r4: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_cnt == '0));

  p_release_latch_r7: assert property (@(posedge clk) disable iff (rst)
    slave_rel |=> (tx_flags[B_REL] && rx_flags[B_REL]));

  p_irq_tx_on_r9: assert property (@(posedge clk) disable iff (rst)
    (|(tx_flags & tx_en)) |=> irq_tx);

  p_irq_tx_off_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(tx_flags & tx_en)) |=> !irq_tx);

  p_irq_rx_on_r9: assert property (@(posedge clk) disable iff (rst)
    (|(rx_flags & rx_en)) |=> irq_rx);

  p_irq_rx_off_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(rx_flags & rx_en)) |=> !irq_rx);
endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_push(tx_push), .eng_tx_pop(eng_tx_pop),
  .tx_flush(tx_flush), .rx_flush(rx_flush), .slave_rel(slave_rel),
  .tx_flags(tx_flags), .rx_flags(rx_flags), .tx_en(tx_en), .rx_en(rx_en),
  .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/tb_spi_fifo_pair.sv
module tb_spi_fifo_pair;
  import spi_fifo_pkg::*;

  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic eng_tx_pop = 1'b0;
  logic [DW-1:0] eng_tx_data;
  logic eng_tx_valid;
  logic eng_rx_push = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic slave_rel = 1'b0;
  logic irq_tx, irq_rx;

  int n_chk = 0;
  int n_bad = 0;
  int tx_lvl = 0;
  int rx_lvl = 0;
  int n_popped = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  always #10 clk = ~clk;

  spi_fifo_pair #(.DW(DW), .DEPTH(16)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .slave_rel(slave_rel), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    v = reg_rdata;
  endtask

  // driver: transmit word into the design, expected item into the scoreboard
  task automatic tx_put(input logic [31:0] d);
    if (tx_lvl < 16) begin
      txq.push_back(d);
      tx_lvl++;
    end
    wr(4'(A_TXDAT), d);
  endtask

  task automatic eng_pop();
    @(negedge clk);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
    if (tx_lvl > 0) tx_lvl--;
  endtask

  task automatic eng_push(input logic [31:0] d);
    if (rx_lvl < 16) begin
      rxq.push_back(d);
      rx_lvl++;
    end
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic rx_get();
    logic [31:0] v;
    logic [31:0] e;
    rd(4'(A_RXDAT), v);
    if (rxq.size() == 0) begin
      e = '0;
      check("R10 read of empty receive buffer", v, e);
    end else begin
      e = rxq.pop_front();
      rx_lvl--;
      check("R1 receive order", v, e);
    end
  endtask

  // monitor: every engine data-valid pulse is matched against the scoreboard
  always @(negedge clk) begin
    if (!rst && eng_tx_valid) begin
      n_popped++;
      if (txq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3 unexpected engine word actual=%h expected=none", eng_tx_data);
      end else begin
        check("R1 R11 transmit order", eng_tx_data, txq.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(4'(A_STATUS), v); check("R2 reset status", v, 32'h0);
    rd(4'(A_TXFLG), v);  check("R5 reset tx flags", v, 32'h22);
    rd(4'(A_RXFLG), v);  check("R6 reset rx flags", v, 32'h0);
    check("R9 reset irq", {30'b0, irq_tx, irq_rx}, 32'h0);

    // thresholds: rx 3, tx 5
    wr(4'(A_CFG), 32'h53);
    rd(4'(A_CFG), v); check("R4 cfg readback", v, 32'h53);

    // full burst of transmit writes with threshold boundary checks
    for (int i = 0; i < 16; i++) begin
      tx_put(32'hA000_0000 + 32'(i));
      if (i == 4) begin rd(4'(A_TXFLG), v); check("R5 level 5 at threshold", v, 32'h20); end
      if (i == 5) begin rd(4'(A_TXFLG), v); check("R5 level 6 above threshold", v, 32'h00); end
    end
    rd(4'(A_STATUS), v); check("R2 tx level 16", v, 32'h0010_0000);
    rd(4'(A_TXFLG), v);  check("R5 full flag", v, 32'h01);
    tx_put(32'hDEAD_BEEF);
    rd(4'(A_STATUS), v); check("R3 push to full ignored", v, 32'h0010_0000);

    for (int i = 0; i < 16; i++) eng_pop();
    eng_pop();
    repeat (2) @(negedge clk);
    check("R3 pop from empty gives no word", 32'(n_popped), 32'd16);
    rd(4'(A_STATUS), v); check("R3 level after drain", v, 32'h0);

    // interleaved traffic across pointer wrap
    for (int i = 0; i < 3; i++) tx_put(32'hB000_0000 + 32'(i));
    eng_pop();
    for (int i = 3; i < 5; i++) tx_put(32'hB000_0000 + 32'(i));
    rd(4'(A_STATUS), v); check("R2 tx level 4", v, 32'h0004_0000);
    for (int i = 0; i < 4; i++) eng_pop();
    repeat (2) @(negedge clk);
    check("R1 interleaved all delivered", 32'(txq.size()), 32'd0);

    // receive threshold boundary: strict comparison
    for (int i = 0; i < 3; i++) eng_push(32'hC000_0000 + 32'(i));
    rd(4'(A_RXFLG), v); check("R6 level 3 not above threshold", v, 32'h00);
    eng_push(32'hC000_0003);
    rd(4'(A_RXFLG), v); check("R6 level 4 above threshold", v, 32'h20);
    rd(4'(A_STATUS), v); check("R2 rx level 4", v, 32'h0000_0400);
    for (int i = 0; i < 4; i++) rx_get();
    rx_get();

    // receive overflow then flush
    for (int i = 0; i < 17; i++) eng_push(32'hD000_0000 + 32'(i));
    rd(4'(A_STATUS), v); check("R3 rx level capped at 16", v, 32'h0000_1000);
    rx_get();
    wr(4'(A_CFG), 32'h853);
    rxq.delete(); rx_lvl = 0;
    rd(4'(A_STATUS), v); check("R4 rx flush empties", v, 32'h0);
    rd(4'(A_CFG), v);    check("R4 flush bits self-clear", v, 32'h53);

    // transmit flush with stored words
    for (int i = 0; i < 4; i++) tx_put(32'hE000_0000 + 32'(i));
    wr(4'(A_CFG), 32'h1053);
    txq.delete(); tx_lvl = 0;
    rd(4'(A_STATUS), v); check("R4 tx flush empties", v, 32'h0);
    eng_pop();
    repeat (2) @(negedge clk);

    // release latch and clear
    @(negedge clk); slave_rel = 1'b1;
    @(negedge clk); slave_rel = 1'b0;
    rd(4'(A_TXFLG), v); check("R7 tx release latched", v, 32'h62);
    rd(4'(A_RXFLG), v); check("R7 rx release latched", v, 32'h40);
    wr(4'(A_TXCLR), 32'hFFFF_FFBF);
    rd(4'(A_TXFLG), v); check("R7 clear without bit 6 ignored", v, 32'h62);
    wr(4'(A_TXCLR), 32'h40);
    rd(4'(A_TXFLG), v); check("R7 tx release cleared", v, 32'h22);
    rd(4'(A_RXFLG), v); check("R7 rx release untouched", v, 32'h40);
    wr(4'(A_RXCLR), 32'h40);
    rd(4'(A_RXFLG), v); check("R7 rx release cleared", v, 32'h00);

    // enables and interrupts
    wr(4'(A_TXEN), 32'hFFFF_FFFF);
    rd(4'(A_TXEN), v); check("R8 tx enable mask", v, 32'h63);
    check("R9 tx irq on empty", {31'b0, irq_tx}, 32'h1);
    wr(4'(A_TXEN), 32'h01);
    @(negedge clk);
    check("R9 tx irq off when only full enabled", {31'b0, irq_tx}, 32'h0);
    wr(4'(A_RXEN), 32'hFF);
    rd(4'(A_RXEN), v); check("R8 rx enable mask", v, 32'h60);
    check("R9 rx irq off below threshold", {31'b0, irq_rx}, 32'h0);
    for (int i = 0; i < 4; i++) eng_push(32'hF000_0000 + 32'(i));
    @(negedge clk);
    check("R9 rx irq on above threshold", {31'b0, irq_rx}, 32'h1);
    for (int i = 0; i < 4; i++) rx_get();
    @(negedge clk);
    check("R9 rx irq off after drain", {31'b0, irq_rx}, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule